// File: doc/BRIEF.md
# Nested Interrupt Acceptance Controller

This block sits between a prioritised interrupt source and a processor core and decides, cycle by cycle, whether the pending request may be taken. It keeps three pieces of state. The first is a global enable bit. The second is an exception-level bit that hardware raises on every acceptance. The third is a 3-bit current level mask. A request is taken only when it outranks that mask.

When a request is taken, the block sets the exception-level bit on its own. It also saves the old mask on a small internal level stack and loads the mask with the level it accepted. Software writes the enable bit, the exception-level bit and the mask through a narrow register write port. Clearing the exception-level bit while in a handler allows higher-level requests to nest. When the core finishes a handler it strobes the return-from-exception input. The block then clears the exception-level bit and restores the saved mask.

Top module: `nest_irq_accept`

## Requirements
- R1: `accept_o` is 1 only while `ie_o` is 1 and `exl_o` is 0; it is combinational from the current state and `req_lvl_i`.
- R2: The clock edge after an acceptance leaves `exl_o` at 1, so a request held high produces exactly one accept pulse.
- R3: A write with `wr_addr_i`=1 loads `exl_o` from `wr_data_i[0]` at the next edge; 0 re-opens acceptance for nesting and 1 blocks it again.
- R4: A request is accepted only if `req_lvl_i` is strictly greater than `mask_o`; level 0 is never accepted and a mask of 7 blocks every level.
- R5: On acceptance `accept_lvl_o` equals `req_lvl_i`, and at the next edge `mask_o` takes that level while the previous mask is pushed onto the level stack.
- R6: A strobe on `eret_i` while `exl_o` is 1 clears `exl_o` at the next edge and, if the stack holds an entry, restores `mask_o` from the most recent entry.
- R7: With `ie_o` at 0 (written with `wr_addr_i`=0 from `wr_data_i[0]`) no request is accepted, whatever `exl_o` and `mask_o` hold.
- R8: When acceptance coincides with a software write to the exception-level bit or the mask (`wr_addr_i`=2, data in `wr_data_i`), the acceptance update wins for both.
- R9: A strobe on `eret_i` while `exl_o` is 0 leaves `exl_o` and `mask_o` unchanged. If the stack is empty, it also sets `err_o`, which stays 1 until reset.
- R10: After reset `ie_o`, `exl_o`, `mask_o` and `err_o` are all 0, and the level stack is empty.
- R11: While the level stack already holds 8 entries, acceptance is withheld and the state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 enable, 1 exception level, 2 mask, 3 none |
| wr_data_i | input | 3 | Write data; bit 0 for the single-bit targets |
| eret_i | input | 1 | Return-from-exception strobe from the core |
| req_lvl_i | input | 3 | Pending request level, 0 = none |
| accept_o | output | 1 | Acceptance pulse |
| accept_lvl_o | output | 3 | Level being accepted |
| ie_o | output | 1 | Global enable bit |
| exl_o | output | 1 | Exception-level bit |
| mask_o | output | 3 | Current level mask |
| err_o | output | 1 | Sticky flag for an unmatched return |

## Verification
Several corner cases are targeted, each with a distinct failure mode:
- Equality against the mask is tested directly. A non-strict comparison would let a request equal to the mask in, and a mask of 7 would then stop blocking level 7.
- Acceptance is made to land in the same cycle as software writes to the exception-level bit and the mask. If software won that collision, the block would reopen itself and admit a second request straight away, or lose the accepted level.
- Return strobes are issued with the exception-level bit already clear. A design that popped anyway would corrupt the mask, and one that ignored an empty stack would never raise the sticky error.
- Eight nested acceptances fill the stack, and a ninth request is then offered. A design that overflowed would accept it and lose the oldest saved mask.

// File: rtl/nia_pkg.sv
package nia_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_EXCLVL = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_NONE   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/nia_rst_sync.sv
module nia_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nia_accept_arb.sv
module nia_accept_arb #(
  parameter int LVL_W = 3
) (
  input  logic             ie,
  input  logic             exl,
  input  logic [LVL_W-1:0] mask,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic             stack_full,
  output logic             accept,
  output logic [LVL_W-1:0] acc_lvl
);
  logic open_gate;
  logic outranks;

  always_comb begin
    open_gate = ie && !exl && !stack_full;
    // Level 0 can never exceed any mask, so no separate test is needed.
    outranks  = (req_lvl > mask);
    accept    = open_gate && outranks;
    acc_lvl   = req_lvl;
  end
endmodule

// File: rtl/nia_level_stack.sv
module nia_level_stack #(
  parameter int LVL_W = 3,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] din,
  output logic [LVL_W-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;
  logic             do_push;
  logic             do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_idx  = cnt_q[PTR_W-1:0];
    rd_idx  = cnt_q[PTR_W-1:0] - PTR_W'(1);
    dout    = mem_q[rd_idx];
    cnt_d   = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Storage carries no reset: an entry is only read after it was written.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_idx] <= din;
  end
endmodule

// File: rtl/nia_ctrl_regs.sv
module nia_ctrl_regs
  import nia_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [LVL_W-1:0] wr_data,
  input  logic             accept,
  input  logic [LVL_W-1:0] acc_lvl,
  input  logic             eret,
  input  logic [LVL_W-1:0] pop_lvl,
  input  logic             stack_empty,
  output logic             pop,
  output logic             ie,
  output logic             exl,
  output logic [LVL_W-1:0] mask,
  output logic             err
);
  logic             ie_q,   ie_d;
  logic             exl_q,  exl_d;
  logic [LVL_W-1:0] mask_q, mask_d;
  logic             err_q,  err_d;
  logic             wr_ie, wr_exl, wr_mask;
  logic             ret_live, ret_idle;

  always_comb begin
    wr_ie    = wr_en && (wr_addr == SEL_ENABLE);
    wr_exl   = wr_en && (wr_addr == SEL_EXCLVL);
    wr_mask  = wr_en && (wr_addr == SEL_MASK);
    ret_live = eret && exl_q;
    ret_idle = eret && !exl_q;
    pop      = ret_live && !stack_empty;

    ie_d = ie_q;
    if (wr_ie) ie_d = wr_data[0];

    // Hardware events take priority over software writes.
    exl_d = exl_q;
    if (accept)        exl_d = 1'b1;
    else if (ret_live) exl_d = 1'b0;
    else if (wr_exl)   exl_d = wr_data[0];

    mask_d = mask_q;
    if (accept)       mask_d = acc_lvl;
    else if (pop)     mask_d = pop_lvl;
    else if (wr_mask) mask_d = wr_data;

    err_d = err_q || (ret_idle && stack_empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      exl_q  <= exl_d;
      mask_q <= mask_d;
      err_q  <= err_d;
    end
  end

  assign ie   = ie_q;
  assign exl  = exl_q;
  assign mask = mask_q;
  assign err  = err_q;
endmodule

// File: rtl/nest_irq_accept.sv
module nest_irq_accept #(
  parameter int LVL_W       = 3,
  parameter int STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [LVL_W-1:0] wr_data_i,
  input  logic             eret_i,
  input  logic [LVL_W-1:0] req_lvl_i,
  output logic             accept_o,
  output logic [LVL_W-1:0] accept_lvl_o,
  output logic             ie_o,
  output logic             exl_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             err_o
);
  logic             rst_n_int;
  logic             stk_empty, stk_full, stk_pop;
  logic [LVL_W-1:0] stk_top;
  logic             acc;
  logic [LVL_W-1:0] acc_lvl;
  logic             ie, exl, err;
  logic [LVL_W-1:0] mask;

  nia_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  nia_accept_arb #(.LVL_W(LVL_W)) u_arb (
    .ie         (ie),
    .exl        (exl),
    .mask       (mask),
    .req_lvl    (req_lvl_i),
    .stack_full (stk_full),
    .accept     (acc),
    .acc_lvl    (acc_lvl)
  );

  nia_level_stack #(.LVL_W(LVL_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n_int),
    .push  (acc),
    .pop   (stk_pop),
    .din   (mask),
    .dout  (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  nia_ctrl_regs #(.LVL_W(LVL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_en       (wr_en_i),
    .wr_addr     (wr_addr_i),
    .wr_data     (wr_data_i),
    .accept      (acc),
    .acc_lvl     (acc_lvl),
    .eret        (eret_i),
    .pop_lvl     (stk_top),
    .stack_empty (stk_empty),
    .pop         (stk_pop),
    .ie          (ie),
    .exl         (exl),
    .mask        (mask),
    .err         (err)
  );

  assign accept_o     = acc;
  assign accept_lvl_o = acc_lvl;
  assign ie_o         = ie;
  assign exl_o        = exl;
  assign mask_o       = mask;
  assign err_o        = err;
endmodule

// File: rtl/nia_checker.sv
module nia_checker #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             eret,
  input logic [LVL_W-1:0] req_lvl,
  input logic             accept,
  input logic [LVL_W-1:0] acc_lvl,
  input logic             ie,
  input logic             exl,
  input logic [LVL_W-1:0] mask,
  input logic             err
);
  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (ie && !exl));

  assert_exl_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> exl);

  assert_outranks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_lvl > mask));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mask == $past(acc_lvl)));

  assert_ret_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && exl) |=> !exl);

  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !accept);

  assert_idle_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exl && !accept && !(wr_en && wr_addr == 2'd2)) |=> $stable(mask));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind nest_irq_accept nia_checker #(.LVL_W(LVL_W)) u_nia_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .eret    (eret_i),
  .req_lvl (req_lvl_i),
  .accept  (accept_o),
  .acc_lvl (accept_lvl_o),
  .ie      (ie_o),
  .exl     (exl_o),
  .mask    (mask_o),
  .err     (err_o)
);

// File: tb/test_nest_irq_accept.sv
module test_nest_irq_accept;
  localparam int PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en_i;
  logic [1:0] wr_addr_i;
  logic [2:0] wr_data_i;
  logic       eret_i;
  logic [2:0] req_lvl_i;
  logic       accept_o;
  logic [2:0] accept_lvl_o;
  logic       ie_o;
  logic       exl_o;
  logic [2:0] mask_o;
  logic       err_o;

  int checks;
  int errors;

  nest_irq_accept i_nest_irq_accept (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .eret_i       (eret_i),
    .req_lvl_i    (req_lvl_i),
    .accept_o     (accept_o),
    .accept_lvl_o (accept_lvl_o),
    .ie_o         (ie_o),
    .exl_o        (exl_o),
    .mask_o       (mask_o),
    .err_o        (err_o)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en_i = 1'b0; wr_addr_i = 2'd3; wr_data_i = 3'd0;
    eret_i = 1'b0; req_lvl_i = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_addr_i = 2'd3; wr_data_i = 3'd0;
  endtask

  task automatic try_req(input logic [2:0] l, input bit exp_acc, input string rq);
    req_lvl_i = l;
    #1;
    chk(rq, "accept", int'(accept_o), int'(exp_acc));
    if (exp_acc) chk(rq, "accept level", int'(accept_lvl_o), int'(l));
    @(negedge clk);
    req_lvl_i = 3'd0;
  endtask

  task automatic ret();
    eret_i = 1'b1;
    @(negedge clk);
    eret_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", "ie", int'(ie_o), 0);
    chk("R10", "exl", int'(exl_o), 0);
    chk("R10", "mask", int'(mask_o), 0);
    chk("R10", "err", int'(err_o), 0);
    try_req(3'd5, 1'b0, "R7");
  endtask

  task automatic t_basic();
    wr(2'd0, 3'd1);
    chk("R7", "ie after write", int'(ie_o), 1);
    try_req(3'd0, 1'b0, "R4");
    try_req(3'd3, 1'b1, "R5");
    chk("R2", "exl after accept", int'(exl_o), 1);
    chk("R5", "mask after accept", int'(mask_o), 3);
    try_req(3'd3, 1'b0, "R2");
    try_req(3'd6, 1'b0, "R1");
  endtask

  task automatic t_nest();
    wr(2'd1, 3'd0);
    chk("R3", "exl cleared", int'(exl_o), 0);
    try_req(3'd3, 1'b0, "R4");
    try_req(3'd2, 1'b0, "R4");
    try_req(3'd6, 1'b1, "R4");
    chk("R5", "mask nested", int'(mask_o), 6);
    wr(2'd1, 3'd0);
    wr(2'd1, 3'd1);
    try_req(3'd7, 1'b0, "R3");
    wr(2'd1, 3'd0);
    try_req(3'd7, 1'b1, "R3");
    wr(2'd1, 3'd0);
    try_req(3'd7, 1'b0, "R4");
    wr(2'd1, 3'd1);
  endtask

  task automatic t_return();
    ret();
    chk("R6", "exl after return", int'(exl_o), 0);
    chk("R6", "mask popped", int'(mask_o), 6);
    ret();
    chk("R9", "exl idle return", int'(exl_o), 0);
    chk("R9", "mask idle return", int'(mask_o), 6);
    chk("R9", "err with entries left", int'(err_o), 0);
    wr(2'd1, 3'd1);
    ret();
    chk("R6", "mask second pop", int'(mask_o), 3);
    wr(2'd1, 3'd1);
    ret();
    chk("R6", "mask third pop", int'(mask_o), 0);
    ret();
    chk("R9", "err on empty", int'(err_o), 1);
    chk("R9", "mask on empty", int'(mask_o), 0);
    @(negedge clk);
    chk("R9", "err sticky", int'(err_o), 1);
  endtask

  task automatic t_collide();
    do_reset();
    wr(2'd0, 3'd1);
    wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = 3'd1;
    try_req(3'd4, 1'b1, "R8");
    wr_en_i = 1'b0; wr_addr_i = 2'd3; wr_data_i = 3'd0;
    chk("R8", "mask wins over write", int'(mask_o), 4);
    wr(2'd1, 3'd0);
    wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 3'd0;
    try_req(3'd5, 1'b1, "R8");
    wr_en_i = 1'b0; wr_addr_i = 2'd3; wr_data_i = 3'd0;
    chk("R8", "exl wins over write", int'(exl_o), 1);
    chk("R8", "mask after second", int'(mask_o), 5);
  endtask

  task automatic t_full();
    do_reset();
    wr(2'd0, 3'd1);
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, 3'd0);
      wr(2'd1, 3'd0);
      try_req(3'd1, 1'b1, "R11");
    end
    wr(2'd2, 3'd0);
    wr(2'd1, 3'd0);
    try_req(3'd1, 1'b0, "R11");
    chk("R11", "exl unchanged", int'(exl_o), 0);
    chk("R11", "mask unchanged", int'(mask_o), 0);
    wr(2'd0, 3'd0);
    wr(2'd2, 3'd0);
    try_req(3'd7, 1'b0, "R7");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    t_reset();
    t_basic();
    t_nest();
    t_return();
    t_collide();
    t_full();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule